// File: doc/BRIEF.md
# I/Q Sample Serial Output Interface

This block turns pairs of 15-bit in-phase and quadrature samples into a framed synchronous serial stream. It runs entirely from one master clock. From that clock it derives a bit clock at one quarter of the master rate and a frame strobe that marks the first bit of every 16-bit word. It presents the data line to the pad ring together with both clocks. Each word holds one 15-bit sample, most significant bit first, followed by a flag bit that says whether the sample is in-phase or quadrature. Words alternate: an in-phase word first, then the quadrature word of the same pair.

When the receive path is enabled, the block waits through a power-up interval before it emits the first bit clock. The interval is longer when offset calibration is on. A new sample pair is taken through a valid/ready handshake once per pair of frames. If no pair is offered, the previous pair is sent again.

A configuration input drives an output-enable signal for the pad ring, so the clock, frame and data pads can be placed in high impedance. The enable does not disturb the internal timing.

Top module: `iqSerialTx`

## Requirements
- R1: While running, bitClk has a period of 4 master-clock cycles. It is high for 2 cycles and low for 2 cycles.
- R2: frameStrobe rises every 64 master-clock cycles and stays high for 4 cycles. Each rise falls in the same cycle as a bitClk rise.
- R3: A word is 16 bits sent over 16 bit-clock periods, starting in the period where frameStrobe is high. Bits 1 to 15 are the 15-bit sample, most significant bit first. Bit 16 is the flag: 0 for an in-phase word, 1 for a quadrature word.
- R4: The first word after start-up is an in-phase word. Words then alternate strictly between in-phase and quadrature.
- R5: serialData changes only in cycles where bitClk rises.
- R6: While rxEnable is high, bitClk first goes high after the 10240th consecutive clock edge with rxEnable high if calEnable is 1, or after the 6144th such edge if calEnable is 0. After rxEnable goes low, all three serial outputs are low from the next cycle, and the start-up count begins again from zero.
- R7: sampleReady is high for exactly one cycle, immediately before each in-phase frame begins. A pair that is valid in that cycle is sent in that in-phase frame and in the quadrature frame that follows it.
- R8: If sampleValid is low in the sampleReady cycle, the previously held pair is sent again. This also holds across an rxEnable off/on cycle.
- R9: padOe takes the value of outEnable one cycle later. 1 means the pads drive and 0 means they are high impedance. outEnable has no effect on bitClk, frameStrobe or serialData timing.
- R10: A synchronous active-high reset drives bitClk, frameStrobe, serialData and padOe low. It also clears the start-up count and the held pair to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rxEnable | input | 1 | Receive power-up enable |
| calEnable | input | 1 | Offset calibration on; selects the long start-up interval |
| outEnable | input | 1 | Pad drive enable configuration bit |
| sampleValid | input | 1 | A sample pair is offered |
| sampleReady | output | 1 | The pair is taken at the next edge |
| sampleI | input | 15 | In-phase sample |
| sampleQ | input | 15 | Quadrature sample |
| bitClk | output | 1 | Derived bit clock |
| frameStrobe | output | 1 | High during the first bit of each word |
| serialData | output | 1 | Serial word data |
| padOe | output | 1 | Output enable for the clock, frame and data pads |

## Verification
The load of a fresh pair and the reload of the shift register for the next in-phase word happen on the same edge. That edge also ends the last flag bit of the quadrature word before it. At start-up, the same edge is the one that launches the first bit clock. The bench offers a new arithmetically generated pair in exactly the sampleReady cycle. It does this both during steady running and at the launch edge, and it skips some offers. It then deserializes the stream on bit-clock rises and compares every in-phase and quadrature word against the pair that the handshake accepted.

// File: rtl/iqSerPkg.sv
package iqSerPkg;
  // Look-ahead strobes from control to datapath: each describes the next edge.
  typedef struct packed {
    logic active;     // serial outputs are live
    logic stepNext;   // next edge begins a new bit
    logic frameNext;  // next edge begins a new word
    logic isQNext;    // the word begun at next edge is quadrature
    logic loadPair;   // next edge accepts a sample pair
  } serCtl_t;
endpackage

// File: rtl/iqSerControl.sv
module iqSerControl
  import iqSerPkg::*;
#(
  parameter int SAMPLE_W      = 15,
  parameter int CLK_DIV       = 4,
  parameter int CAL_ON_CYCLES = 10240,
  parameter int CAL_OFF_CYCLES = 6144
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    rxEnable,
  input  logic    calEnable,
  output serCtl_t ctl,
  output logic    bitClkLvl,
  output logic    frameLvl
);
  localparam int WORD_W    = SAMPLE_W + 1;
  localparam int DIV_W     = $clog2(CLK_DIV);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int HIGH_CYC  = CLK_DIV / 2;
  localparam int MAX_START = (CAL_ON_CYCLES > CAL_OFF_CYCLES) ? CAL_ON_CYCLES : CAL_OFF_CYCLES;
  localparam int START_W   = $clog2(MAX_START + 1);
  localparam logic [START_W-1:0] ON_LAST  = START_W'(CAL_ON_CYCLES - 1);
  localparam logic [START_W-1:0] OFF_LAST = START_W'(CAL_OFF_CYCLES - 1);
  localparam logic [DIV_W-1:0]   DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0]   BIT_LAST = BIT_W'(WORD_W - 1);

  logic [START_W-1:0] startCnt;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               running;
  logic               isQ;
  logic               launch;
  logic               divWrap;
  logic               wordWrap;
  logic [START_W-1:0] startLast;

  assign startLast = calEnable ? ON_LAST : OFF_LAST;
  assign launch    = rxEnable && !running && (startCnt >= startLast);
  assign divWrap   = running && rxEnable && (divCnt == DIV_LAST);
  assign wordWrap  = divWrap && (bitCnt == BIT_LAST);

  always_comb begin
    ctl.active    = running;
    ctl.stepNext  = launch || divWrap;
    ctl.frameNext = launch || wordWrap;
    ctl.isQNext   = launch ? 1'b0 : !isQ;
    ctl.loadPair  = launch || (wordWrap && isQ);
  end

  always_ff @(posedge clk) begin
    if (rst || !rxEnable) begin
      startCnt <= '0;
      running  <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      isQ      <= 1'b0;
    end else if (!running) begin
      if (launch) begin
        running <= 1'b1;
        divCnt  <= '0;
        bitCnt  <= '0;
        isQ     <= 1'b0;
      end else begin
        startCnt <= startCnt + 1'b1;
      end
    end else begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
      if (divWrap) bitCnt <= wordWrap ? '0 : bitCnt + 1'b1;
      if (wordWrap) isQ <= !isQ;
    end
  end

  assign bitClkLvl = running && (divCnt < DIV_W'(HIGH_CYC));
  assign frameLvl  = running && (bitCnt == '0);

  AST_CLK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    ($rose(bitClkLvl) && $past(running, 4)) |-> ($past(bitClkLvl, 4) && !$past(bitClkLvl, 2))); // R1
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(frameLvl) |-> $rose(bitClkLvl)); // R2
  AST_READY_BEFORE_I: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadPair && rxEnable) |=> (frameLvl && !isQ && $rose(bitClkLvl))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bitClkLvl && !frameLvl && !running)); // R10
endmodule

// File: rtl/iqSerDatapath.sv
module iqSerDatapath
  import iqSerPkg::*;
#(
  parameter int SAMPLE_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  serCtl_t             ctl,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  output logic                serialData
);
  localparam int WORD_W = SAMPLE_W + 1;

  logic [SAMPLE_W-1:0] holdI;
  logic [SAMPLE_W-1:0] holdQ;
  logic [WORD_W-1:0]   shiftReg;
  logic                accept;
  logic [SAMPLE_W-1:0] nextI;

  assign accept = ctl.loadPair && sampleValid;
  assign nextI  = accept ? sampleI : holdI;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdI    <= '0;
      holdQ    <= '0;
      shiftReg <= '0;
    end else begin
      if (accept) begin
        holdI <= sampleI;
        holdQ <= sampleQ;
      end
      if (ctl.frameNext)
        shiftReg <= ctl.isQNext ? {holdQ, 1'b1} : {nextI, 1'b0};
      else if (ctl.stepNext)
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serialData = ctl.active && shiftReg[WORD_W-1];

  AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && $past(ctl.active) && !$past(ctl.stepNext)) |-> $stable(serialData)); // R5
endmodule

// File: rtl/iqSerialTx.sv
module iqSerialTx
  import iqSerPkg::*;
#(
  parameter int SAMPLE_W       = 15,
  parameter int CLK_DIV        = 4,
  parameter int CAL_ON_CYCLES  = 10240,
  parameter int CAL_OFF_CYCLES = 6144
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxEnable,
  input  logic                calEnable,
  input  logic                outEnable,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  output logic                bitClk,
  output logic                frameStrobe,
  output logic                serialData,
  output logic                padOe
);
  serCtl_t ctl;

  iqSerControl #(
    .SAMPLE_W(SAMPLE_W), .CLK_DIV(CLK_DIV),
    .CAL_ON_CYCLES(CAL_ON_CYCLES), .CAL_OFF_CYCLES(CAL_OFF_CYCLES)
  ) i_control (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .calEnable(calEnable),
    .ctl(ctl), .bitClkLvl(bitClk), .frameLvl(frameStrobe)
  );

  iqSerDatapath #(.SAMPLE_W(SAMPLE_W)) i_datapath (
    .clk(clk), .rst(rst), .ctl(ctl), .sampleValid(sampleValid),
    .sampleI(sampleI), .sampleQ(sampleQ), .serialData(serialData)
  );

  assign sampleReady = ctl.loadPair;

  always_ff @(posedge clk) begin
    if (rst) padOe <= 1'b0;
    else     padOe <= outEnable;
  end

  AST_PAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (padOe == $past(outEnable))); // R9
endmodule

// File: tb/test_iqSerialTx.sv
`timescale 1ns/1ps
module test_iqSerialTx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxEnable = 1'b0;
  logic calEnable = 1'b1;
  logic outEnable = 1'b1;
  logic sampleValid = 1'b0;
  logic [14:0] sampleI = '0;
  logic [14:0] sampleQ = '0;
  logic sampleReady, bitClk, frameStrobe, serialData, padOe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iqSerialTx i_iqSerialTx (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .calEnable(calEnable),
    .outEnable(outEnable), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sampleI(sampleI), .sampleQ(sampleQ), .bitClk(bitClk),
    .frameStrobe(frameStrobe), .serialData(serialData), .padOe(padOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pair, updated when the bench sees its offer accepted.
  logic [14:0] curI = '0;
  logic [14:0] curQ = '0;
  bit monReset = 1'b1;

  // Stream monitor: deserializes on bit-clock rises.
  int cyc = 0, lastRise = -1, highStart = -1, lastFr = -1, bitPos = 0;
  bit prevClk = 0, prevFrame = 0, prevData = 0, prevReady = 0, synced = 0, expectQ = 0;
  logic [15:0] word = '0;

  always @(negedge clk) begin
    bit rise, fall, frRise, frFall;
    cyc++;
    rise   = bitClk && !prevClk;
    fall   = !bitClk && prevClk;
    frRise = frameStrobe && !prevFrame;
    frFall = !frameStrobe && prevFrame;
    if (monReset || rst) begin
      lastRise = -1; highStart = -1; lastFr = -1; synced = 0; expectQ = 0; bitPos = 0;
    end else begin
      if (rise) begin
        if (lastRise >= 0) check(cyc - lastRise == 4, "R1 bit clock period", cyc - lastRise, 4);
        lastRise = cyc; highStart = cyc;
      end
      if (fall && highStart >= 0) check(cyc - highStart == 2, "R1 bit clock high time", cyc - highStart, 2);
      if (frRise) begin
        check(rise, "R2 frame rise with bit clock rise", int'(rise), 1);
        if (lastFr >= 0) check(cyc - lastFr == 64, "R2 frame period", cyc - lastFr, 64);
        lastFr = cyc;
      end
      if (frFall && lastFr >= 0) check(cyc - lastFr == 4, "R2 frame high time", cyc - lastFr, 4);
      if (!rise && serialData != prevData)
        check(0, "R5 data changed off bit clock rise", int'(serialData), int'(prevData));
      if (prevReady)
        check(frRise && !expectQ, "R7 ready precedes I frame", int'(frRise), 1);
      if (rise) begin
        if (frameStrobe) begin synced = 1; bitPos = 0; word = '0; end
        if (synced) begin
          word = {word[14:0], serialData};
          bitPos++;
          if (bitPos == 16) begin
            check(word[0] == expectQ, "R4 flag order", int'(word[0]), int'(expectQ));
            check(word[15:1] == (expectQ ? curQ : curI), "R3 word sample",
                  int'(word[15:1]), int'(expectQ ? curQ : curI));
            expectQ = !expectQ;
            synced = 0;
          end
        end
      end
    end
    prevClk = bitClk; prevFrame = frameStrobe; prevData = serialData; prevReady = sampleReady;
  end

  task automatic startup(input bit cal, input int expN, input string req);
    int n = 0;
    calEnable = cal;
    monReset = 1'b0;
    rxEnable = 1'b1;
    while (!bitClk && n < 20000) begin
      @(negedge clk);
      n++;
      if (!bitClk && (frameStrobe || serialData))
        check(0, "R6 outputs quiet during start-up", 1, 0);
    end
    check(n == expN, req, n, expN);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bitClk && !frameStrobe && !serialData, "R10 outputs low in reset",
          int'({bitClk, frameStrobe, serialData}), 0);
    check(padOe == 1'b0, "R10 padOe low in reset", int'(padOe), 0);
    rst = 1'b0;
    @(negedge clk);
    check(padOe == 1'b1, "R9 padOe follows outEnable", int'(padOe), 1);

    // Long start-up; no pair offered, so the held zero pair goes out (R10, R8).
    startup(1'b1, 10240, "R6 start-up with calibration");
    repeat (260) @(negedge clk);

    // Sweep of pairs, some offers skipped.
    for (int k = 0; k < 48; k++) begin
      logic [14:0] vi, vq;
      vi = 15'((k * 2731 + 5) ^ (k << 9));
      vq = 15'((k * 9973) ^ 16'h5555);
      if (k % 8 == 0) begin vi = 15'h7fff; vq = 15'h0000; end
      if (k % 8 == 4) begin vi = 15'h0001; vq = 15'h4000; end
      if (k % 5 == 3) begin
        sampleValid = 1'b0;  // R8: pair repeats
        @(negedge clk);
        while (!sampleReady) @(negedge clk);
      end else begin
        sampleI = vi; sampleQ = vq; sampleValid = 1'b1;
        @(negedge clk);
        while (!sampleReady) @(negedge clk);
        curI = vi; curQ = vq;
      end
      @(negedge clk);
      sampleValid = 1'b0;
      if (k == 20) begin
        outEnable = 1'b0;
        @(negedge clk);
        check(padOe == 1'b0, "R9 padOe off one cycle later", int'(padOe), 0);
      end
      if (k == 30) begin
        outEnable = 1'b1;
        @(negedge clk);
        check(padOe == 1'b1, "R9 padOe on one cycle later", int'(padOe), 1);
      end
    end
    repeat (140) @(negedge clk);

    // Power down mid-stream.
    monReset = 1'b1;
    rxEnable = 1'b0;
    @(negedge clk);
    check(!bitClk && !frameStrobe && !serialData, "R6 outputs low after rxEnable drop",
          int'({bitClk, frameStrobe, serialData}), 0);
    repeat (10) @(negedge clk);

    // Short start-up with a fresh pair offered right at the launch edge.
    sampleI = 15'h2a5c; sampleQ = 15'h51e3; sampleValid = 1'b1;
    startup(1'b0, 6144, "R6 start-up without calibration");
    curI = 15'h2a5c; curQ = 15'h51e3;
    sampleValid = 1'b0;
    repeat (300) @(negedge clk);

    // Power cycle with no offer: pair persists (R8).
    monReset = 1'b1;
    rxEnable = 1'b0;
    repeat (5) @(negedge clk);
    startup(1'b0, 6144, "R6 restart count from zero");
    repeat (300) @(negedge clk);

    // Reset while running.
    monReset = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(!bitClk && !frameStrobe && !serialData && !padOe, "R10 reset while running",
          int'({bitClk, frameStrobe, serialData, padOe}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule